// File: doc/BRIEF.md
# Bus Arbiter with Interrupt Priority Boost

This block decides which of several requesters owns a shared system bus. Only one requester owns the bus at a time. The processor core is one of the requesters, and it always sits at the highest index. Each requester raises its bit in a request vector, and the block answers with a registered grant vector. A grant is never taken away: the owner keeps the bus until it lowers its own request. Every other requester waits, even one with higher priority.

A small control register chooses how contention is resolved. In fixed mode, lower indices win. In rotating mode, the search for the next owner starts just after the previous owner, so every requester gets a turn. The register also has a boost-enable bit. When boost is enabled and an unmasked interrupt is pending (the `irq_pending` input), the core moves up in fixed mode from last place to directly behind requester 0. A read-only status bit reports when this boost is in effect.

Top module: `bus_arbiter_boost`

## Requirements
- R1: The grant vector is always zero or one-hot.
- R2: While the owner keeps its request high, the grant stays unchanged, whatever the other requests do.
- R3: Timing of the grant. When the grant is zero and at least one request is high, the chosen requester's grant bit rises on the next clock edge. When the owner's request is low, the grant clears on the next clock edge. A new owner is chosen only from a cycle in which the grant is zero.
- R4: Layout of the control register. It reads all zeros after reset. Bit 0 selects the priority mode (0 = fixed, 1 = rotating). Bit 22 is boost enable. Bit 23 is the read-only boost status. All other bits read 0 and ignore writes. A write takes effect on the next clock edge.
- R5: In fixed mode with no boost active, the lowest requesting index wins. Index 0 is highest and the core (index N-1) is lowest.
- R6: With boost enable at 0, the core keeps the lowest priority whatever the state of `irq_pending`, and status bit 23 reads 0.
- R7: With boost enable at 1 and `irq_pending` low, the core keeps the lowest priority and bit 23 reads 0.
- R8: With boost enable at 1 and `irq_pending` high, bit 23 reads 1 in the same cycle. In fixed mode the priority order then becomes 0, core, 1, 2, … N-2.
- R9: In rotating mode, the search order starts at the index after the last owner and wraps around. After reset the search starts at index 0. The boost does not change the rotating order. If all requesters request continuously, each one gets an equal share of grants.
- R10: With no request high while the grant is zero, the grant stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | NUM_MASTERS | Bus request per master; the core is the top index |
| irq_pending | input | 1 | An unmasked interrupt is pending for the core |
| cfg_wr_en | input | 1 | Write strobe for the control register |
| cfg_wr_data | input | 32 | Write data for the control register |
| cfg_rd_data | output | 32 | Control/status register read value (combinational) |
| gnt | output | NUM_MASTERS | Registered one-hot bus grant |

## Verification
A grant is due one clock edge after an idle cycle in which a request is present. A release clears the grant one edge after the owner's request drops. A register write shows up in the read value after one edge. The boost status follows `irq_pending` in the same cycle, with no edge in between. The bench drives each input set just after a falling edge and advances its own model at the rising edge, using the values that were present before that edge. It then compares the grant and the register read-back at the next falling edge, so each result is checked exactly in the cycle it is due. Directed sequences cover the boost cases, holding the bus against a higher-priority request, and a fairness count in rotating mode. These are followed by seeded random traffic that mixes mode and boost writes.

// File: rtl/bus_arb_pkg.sv
// Shared constants and types for the bus arbiter.
// Assumes a 32-bit control register; bit positions are fixed here.
package bus_arb_pkg;
    localparam int CFG_W        = 32;
    localparam int MODE_BIT     = 0;
    localparam int BOOST_EN_BIT = 22;
    localparam int BOOST_ST_BIT = 23;

    typedef enum logic {
        PRIO_FIXED  = 1'b0,
        PRIO_ROTATE = 1'b1
    } prio_mode_e;
endpackage

// File: rtl/arb_cfg_reg.sv
// Control/status register: holds the priority mode and the boost enable,
// and derives the live boost status from the interrupt input.
// Assumes the caller gives a single-cycle write strobe; reads are combinational.
module arb_cfg_reg
    import bus_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             irq_pending,
    output prio_mode_e       mode,
    output logic             boost_act,
    output logic [CFG_W-1:0] rd_data
);
    logic boost_en;
    logic unused_wr_bits;

    // Register the writable fields; the status bit is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= PRIO_FIXED;
            boost_en <= 1'b0;
        end else if (wr_en) begin
            mode     <= prio_mode_e'(wr_data[MODE_BIT]);
            boost_en <= wr_data[BOOST_EN_BIT];
        end
    end

    // The boost is live only while enabled and an interrupt is pending.
    assign boost_act = boost_en & irq_pending;

    // Assemble the read view; unused bits read zero.
    always_comb begin
        rd_data               = '0;
        rd_data[MODE_BIT]     = mode;
        rd_data[BOOST_EN_BIT] = boost_en;
        rd_data[BOOST_ST_BIT] = boost_act;
    end

    assign unused_wr_bits = ^{wr_data[CFG_W-1:BOOST_EN_BIT+1],
                              wr_data[BOOST_EN_BIT-1:MODE_BIT+1]};
endmodule

// File: rtl/arb_fixed_pick.sv
// Fixed-priority selector. Normal order is ascending index with the core
// (top index) last. When the boost is active the core moves to second place,
// directly behind index 0. Purely combinational.
module arb_fixed_pick #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic             boost,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    localparam int CORE = N - 1;

    // Map a priority position to a master index.
    function automatic int pos_to_master(int p, logic b);
        if (!b || p == 0) return p;
        if (p == 1)       return CORE;
        return p - 1;
    endfunction

    // Scan from the lowest priority up so the highest-priority hit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int p = N - 1; p >= 0; p--) begin
            if (req[pos_to_master(p, boost)]) begin
                found = 1'b1;
                idx   = IDX_W'(pos_to_master(p, boost));
            end
        end
    end
endmodule

// File: rtl/arb_rr_pick.sv
// Rotating-priority selector: the search starts at the index after the last
// owner and wraps, so the last owner is considered last. Combinational.
module arb_rr_pick #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    input  logic [IDX_W-1:0] last_idx,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Walk offsets from farthest to nearest so the nearest requester wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int off = N; off >= 1; off--) begin
            int cand;
            cand = int'(last_idx) + off;
            if (cand >= N) cand = cand - N;
            if (req[cand]) begin
                found = 1'b1;
                idx   = IDX_W'(cand);
            end
        end
    end
endmodule

// File: rtl/arb_grant_ctrl.sv
// Ownership state: issues a registered one-hot grant from an idle cycle,
// holds it while the owner requests, and clears it after release.
// Remembers the last owner for the rotating selector.
module arb_grant_ctrl #(
    parameter int N     = 4,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             pick_found,
    input  logic [IDX_W-1:0] pick_idx,
    output logic [N-1:0]     gnt,
    output logic [IDX_W-1:0] last_idx
);
    localparam logic [N-1:0]     ONE      = {{(N-1){1'b0}}, 1'b1};
    localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(N - 1);

    logic bus_idle;
    logic owner_done;

    assign bus_idle   = (gnt == '0);
    assign owner_done = ((req & gnt) == '0);

    // Grant on idle, hold while owned, release one cycle after the request drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gnt      <= '0;
            last_idx <= LAST_RST;
        end else if (bus_idle) begin
            if (pick_found) begin
                gnt      <= ONE << pick_idx;
                last_idx <= pick_idx;
            end
        end else if (owner_done) begin
            gnt <= '0;
        end
    end
endmodule

// File: rtl/bus_arbiter_boost.sv
// Non-preemptive bus arbiter for NUM_MASTERS requesters with fixed or rotating
// priority and an interrupt-driven priority raise for the core (top index).
// Assumes NUM_MASTERS >= 3 and that requesters hold req until granted.
module bus_arbiter_boost
    import bus_arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    input  logic                   irq_pending,
    input  logic                   cfg_wr_en,
    input  logic [CFG_W-1:0]       cfg_wr_data,
    output logic [CFG_W-1:0]       cfg_rd_data,
    output logic [NUM_MASTERS-1:0] gnt
);
    localparam int IDX_W = $clog2(NUM_MASTERS);

    prio_mode_e       mode;
    logic             boost_act;
    logic             fx_found, rr_found, sel_found;
    logic [IDX_W-1:0] fx_idx, rr_idx, sel_idx, last_idx;

    arb_cfg_reg u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_data     (cfg_wr_data),
        .irq_pending (irq_pending),
        .mode        (mode),
        .boost_act   (boost_act),
        .rd_data     (cfg_rd_data)
    );

    arb_fixed_pick #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_fixed (
        .req   (req),
        .boost (boost_act),
        .found (fx_found),
        .idx   (fx_idx)
    );

    arb_rr_pick #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_rr (
        .req      (req),
        .last_idx (last_idx),
        .found    (rr_found),
        .idx      (rr_idx)
    );

    // Choose the selector that the mode bit names.
    always_comb begin
        if (mode == PRIO_ROTATE) begin
            sel_found = rr_found;
            sel_idx   = rr_idx;
        end else begin
            sel_found = fx_found;
            sel_idx   = fx_idx;
        end
    end

    arb_grant_ctrl #(.N(NUM_MASTERS), .IDX_W(IDX_W)) u_own (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .pick_found (sel_found),
        .pick_idx   (sel_idx),
        .gnt        (gnt),
        .last_idx   (last_idx)
    );
endmodule

// File: rtl/bus_arbiter_boost_chk.sv
// Property checker for bus_arbiter_boost, attached with bind below.
// Observes only the top-level ports.
module bus_arbiter_boost_chk #(
    parameter int NUM_MASTERS = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_MASTERS-1:0] req,
    input logic [NUM_MASTERS-1:0] gnt,
    input logic                   cfg_wr_en,
    input logic                   wr_mode,
    input logic                   wr_en_bit,
    input logic                   rd_mode,
    input logic                   rd_en_bit,
    input logic                   rd_status
);
    localparam int CORE = NUM_MASTERS - 1;

    AST_GNT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt)); // R1

    AST_GNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && (req & gnt) != '0) |=> (gnt == $past(gnt))); // R2

    AST_GNT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt != '0 && (req & gnt) == '0) |=> (gnt == '0)); // R3

    AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (rd_mode == $past(wr_mode) && rd_en_bit == $past(wr_en_bit))); // R4

    AST_FIXED_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && !rd_mode && req[0]) |=> gnt[0]); // R5

    AST_CORE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && !rd_mode && !rd_status && req[CORE] && req[CORE-1:0] != '0)
        |=> !gnt[CORE]); // R7

    AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_bit |-> !rd_status); // R6

    AST_BOOST_WIN: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && !rd_mode && rd_status && !req[0] && req[CORE]) |=> gnt[CORE]); // R8

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt == '0 && req == '0) |=> (gnt == '0)); // R10
endmodule

bind bus_arbiter_boost bus_arbiter_boost_chk #(.NUM_MASTERS(NUM_MASTERS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .gnt       (gnt),
    .cfg_wr_en (cfg_wr_en),
    .wr_mode   (cfg_wr_data[0]),
    .wr_en_bit (cfg_wr_data[22]),
    .rd_mode   (cfg_rd_data[0]),
    .rd_en_bit (cfg_rd_data[22]),
    .rd_status (cfg_rd_data[23])
);

// File: tb/sim_bus_arbiter_boost.sv
`timescale 1ns/1ps
module sim_bus_arbiter_boost;
    localparam int NM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NM-1:0] req = '0;
    logic          irq_pending = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [31:0]   cfg_wr_data = '0;
    logic [31:0]   cfg_rd_data;
    logic [NM-1:0] gnt;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [NM-1:0] m_gnt = '0;
    logic          m_mode = 1'b0;
    logic          m_en = 1'b0;
    int            m_last = NM - 1;

    always #2 clk = ~clk;

    bus_arbiter_boost #(.NUM_MASTERS(NM)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .irq_pending(irq_pending),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .gnt(gnt)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Winner from the requirement text: fixed order with optional boost, or rotation.
    function automatic logic [NM-1:0] model_pick(logic [NM-1:0] r, logic mode,
                                                 logic boost, int last);
        int ord[NM];
        logic [NM-1:0] res = '0;
        logic hit = 1'b0;
        for (int k = 0; k < NM; k++) begin
            if (mode) ord[k] = (last + 1 + k) % NM;
            else if (boost && k == 1) ord[k] = NM - 1;
            else if (boost && k > 1) ord[k] = k - 1;
            else ord[k] = k;
        end
        for (int k = 0; k < NM; k++) begin
            if (!hit && r[ord[k]]) begin
                hit = 1'b1;
                res[ord[k]] = 1'b1;
            end
        end
        return res;
    endfunction

    function automatic logic [31:0] exp_reg();
        logic [31:0] v = '0;
        v[0]  = m_mode;
        v[22] = m_en;
        v[23] = m_en & irq_pending;
        return v;
    endfunction

    // One cycle: drive, advance model at the rising edge, compare at the falling edge.
    task automatic step(logic [NM-1:0] r, logic irq, logic we, logic [31:0] wd);
        logic [NM-1:0] nxt;
        string tag;
        req = r; irq_pending = irq; cfg_wr_en = we; cfg_wr_data = wd;
        @(posedge clk);
        if (m_gnt == '0) begin
            nxt = model_pick(r, m_mode, m_en & irq, m_last);
            if (r == '0) tag = "R10 idle";
            else if (m_mode) tag = "R9 rotate";
            else if (m_en & irq) tag = "R8 boosted";
            else if (m_en) tag = "R7 enabled-no-irq";
            else tag = "R5 fixed";
            for (int k = 0; k < NM; k++) if (nxt[k]) m_last = k;
        end else if ((r & m_gnt) != '0) begin
            nxt = m_gnt; tag = "R2 hold";
        end else begin
            nxt = '0; tag = "R3 release";
        end
        if (we) begin m_mode = wd[0]; m_en = wd[22]; end
        m_gnt = nxt;
        @(negedge clk);
        check(tag, 32'(gnt), 32'(m_gnt));
        check("R1 onehot0", 32'($onehot0(gnt)), 32'd1);
        check("R4 register", cfg_rd_data, exp_reg());
    endtask

    // Watchdog: an expired run is a failed check and still prints the summary.
    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int cnt[NM];
        int held;
        int total;
        logic [NM-1:0] r;
        logic irq_r;
        void'($urandom(32'h5eed_0a1b));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R4 reset read", cfg_rd_data, 32'h0);
        check("R10 reset grant", 32'(gnt), 32'h0);

        // Register layout: only bits 0 and 22 store; bit 23 follows irq.
        step('0, 1'b0, 1'b1, 32'hFFFF_FFFF);
        check("R4 write all ones", cfg_rd_data, 32'h0040_0001);
        step('0, 1'b1, 1'b1, 32'h0040_0000);
        check("R8 status set", cfg_rd_data, 32'h00C0_0000);

        // Boost active, fixed mode: core (3) beats index 2.
        step(4'b1100, 1'b1, 1'b0, '0);
        check("R8 core wins boosted", 32'(gnt), 32'h8);
        step('0, 1'b1, 1'b0, '0);
        // Enabled, no interrupt: core stays last.
        step(4'b1100, 1'b0, 1'b0, '0);
        check("R7 core last no irq", 32'(gnt), 32'h4);
        check("R7 status clear", 32'(cfg_rd_data[23]), 32'h0);
        step('0, 1'b0, 1'b0, '0);
        // Disable boost; interrupt pending has no effect.
        step('0, 1'b1, 1'b1, 32'h0);
        step(4'b1100, 1'b1, 1'b0, '0);
        check("R6 core last when disabled", 32'(gnt), 32'h4);
        check("R6 status clear", 32'(cfg_rd_data[23]), 32'h0);
        // Higher-priority request arrives while 2 owns the bus.
        for (int i = 0; i < 3; i++) step(4'b0101, 1'b1, 1'b0, '0);
        check("R2 owner kept", 32'(gnt), 32'h4);
        step(4'b0001, 1'b1, 1'b0, '0);
        check("R3 cleared after release", 32'(gnt), 32'h0);
        step(4'b0001, 1'b1, 1'b0, '0);
        check("R3 new owner after idle", 32'(gnt), 32'h1);
        step('0, 1'b0, 1'b0, '0);
        step('0, 1'b0, 1'b0, '0);

        // Rotating mode fairness under continuous requests from everyone.
        step('0, 1'b1, 1'b1, 32'h0040_0001);
        for (int k = 0; k < NM; k++) cnt[k] = 0;
        held = 0; total = 0;
        for (int i = 0; i < 1000 && total < 10 * NM; i++) begin
            logic [NM-1:0] prev;
            prev = m_gnt;
            r = '1;
            if (m_gnt != '0 && held >= 2) r = r & ~m_gnt;
            step(r, 1'b1, 1'b0, '0);
            if (prev == '0 && m_gnt != '0) begin
                total++;
                for (int k = 0; k < NM; k++) if (m_gnt[k]) cnt[k]++;
            end
            held = (m_gnt != '0) ? held + 1 : 0;
        end
        for (int k = 0; k < NM; k++) check("R9 fair share", 32'(cnt[k]), 32'd10);

        // Seeded random traffic with occasional mode and boost changes.
        irq_r = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            logic we;
            logic [31:0] wd;
            r = NM'($urandom);
            if (m_gnt != '0 && ($urandom % 4) != 0) r = r | m_gnt;
            if (($urandom % 8) == 0) irq_r = ~irq_r;
            we = (($urandom % 32) == 0);
            wd = $urandom;
            step(r, irq_r, we, wd);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule